// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column command into the run of column addresses that a memory burst visits. A command carries a start column, a burst length code and an order bit. Once the command is taken, the block presents one address per beat on an output stream, together with a flag that marks the final beat of the burst. The addresses stay inside the aligned group of burst-length columns that holds the start column. Only the low bits move, and they wrap inside that group. Sequential order counts those low bits upward modulo the length. Interleaved order XORs the beat number into them. The start column may be even or odd.

Both sides use a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. A beat is consumed on an edge where `beat_valid` and `beat_ready` are both high. While the consumer holds `beat_ready` low, the current beat is held and no state advances. A plain `stop_req` input cuts a burst short. While a beat is being presented, `stop_req` forces the last flag on that beat, and the burst ends when that beat is consumed. A new command can be taken on the same edge that consumes the final beat, so back-to-back bursts run with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: The first beat after a command is taken shows that command's column unchanged, starting on the cycle after the taking edge.
- R2: In sequential order (`cmd_ilv`=0), beat k carries the low log2(BL) bits equal to (start + k) mod BL, and the upper bits equal to those of the start column.
- R3: In interleaved order (`cmd_ilv`=1), beat k carries the low log2(BL) bits equal to (start XOR k), and the upper bits equal to those of the start column.
- R4: Length code `cmd_len` 0 gives 2 beats, 1 gives 4 beats, and 2 or 3 give 8 beats.
- R5: Without a stop, `beat_last` is high on beat BL-1 and low on every earlier beat.
- R6: While `beat_valid` is high, `stop_req` forces `beat_last` high, and the burst ends when that beat is consumed. While no burst runs, `stop_req` has no effect: `beat_valid` stays low and `cmd_ready` stays high.
- R7: While `beat_valid` is high and `beat_ready` is low, the same beat (address and position) is presented again on the next cycle.
- R8: `cmd_ready` is high when no burst runs, and also during the cycle in which the last beat is being consumed. A command taken in that cycle presents its first beat on the very next cycle.
- R9: During reset, `beat_valid` is low and `cmd_ready` is high.
- R10: If no new command is taken when the last beat is consumed, `beat_valid` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_col | input | COL_W (10) | Start column of the burst |
| cmd_len | input | 2 | Length code: 0=2, 1=4, 2 or 3=8 beats |
| cmd_ilv | input | 1 | 0 sequential order, 1 interleaved order |
| stop_req | input | 1 | End the burst on the beat now presented |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | Consumer takes the presented beat |
| beat_col | output | COL_W (10) | Column address of the presented beat |
| beat_last | output | 1 | Presented beat is the final one of its burst |

## Verification
The bench builds the block with the default 10-bit column. Random start columns therefore hit every alignment of the low three bits and random upper bits, for all four length codes and both orders. Random back-pressure, rare stops and frequent command offers produce held beats, early endings, stops while idle and back-to-back bursts. Directed cases come first: an odd start at length 8 in each order, and a top-of-range column that must wrap without touching the upper bits.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  // Widest burst is 2**MAX_LOG beats; beat index width follows from it.
  localparam int unsigned MAX_LOG = 3;

  typedef enum logic [1:0] {
    LEN_2  = 2'd0,
    LEN_4  = 2'd1,
    LEN_8  = 2'd2,
    LEN_8B = 2'd3
  } len_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  // Window mask (BL-1) for a length code; also the index of the final beat.
  function automatic logic [MAX_LOG-1:0] len_mask(input len_code_e code);
    case (code)
      LEN_2:   len_mask = MAX_LOG'(1);
      LEN_4:   len_mask = MAX_LOG'(3);
      default: len_mask = MAX_LOG'(7);
    endcase
  endfunction
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  output logic             cmd_take,
  input  logic [IDX_W-1:0] end_idx,
  input  logic             stop_req,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic             beat_last,
  output logic [IDX_W-1:0] beat_idx
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] end_q;
  logic             beat_fire;
  logic             burst_done;

  assign beat_valid = busy_q;
  assign beat_idx   = idx_q;
  assign beat_last  = busy_q & ((idx_q == end_q) | stop_req);
  assign beat_fire  = busy_q & beat_ready;
  assign burst_done = beat_fire & beat_last;
  assign cmd_ready  = ~busy_q | burst_done;
  assign cmd_take   = cmd_valid & cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      end_q  <= '0;
    end else if (cmd_take) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      end_q  <= end_idx;
    end else if (burst_done) begin
      busy_q <= 1'b0;
    end else if (beat_fire) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // R5: the beat index never runs past the final beat of the burst
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_idx <= end_q));
  // R7: a stalled beat is held in place
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_idx)));
  // R10: the stream goes quiet after the last beat when nothing follows
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last && !cmd_valid) |=> !beat_valid);
  // R8: a command taken on the last beat starts at beat zero next cycle
  a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last && cmd_valid) |=> (beat_valid && beat_idx == '0));
  // R6: a stop on a presented beat marks it final
  a_r6_stop_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && stop_req) |-> beat_last);
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
  parameter int unsigned COL_W = 10,
  parameter int unsigned IDX_W = 3
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [IDX_W-1:0] win_mask,
  input  logic             ilv,
  input  logic [IDX_W-1:0] idx,
  output logic [COL_W-1:0] col
);
  logic [IDX_W-1:0] low_seq;
  logic [IDX_W-1:0] low_ilv;
  logic [IDX_W-1:0] low_mix;

  assign low_seq = start_col[IDX_W-1:0] + idx;
  assign low_ilv = start_col[IDX_W-1:0] ^ idx;
  assign low_mix = ilv ? low_ilv : low_seq;

  // Inside the window a bit takes the mixed value; outside it the start bit
  // passes, which also drops any carry past the window edge.
  for (genvar b = 0; b < IDX_W; b++) begin : g_low
    assign col[b] = win_mask[b] ? low_mix[b] : start_col[b];
  end

  if (COL_W > IDX_W) begin : g_high
    assign col[COL_W-1:IDX_W] = start_col[COL_W-1:IDX_W];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bseq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [1:0]       cmd_len,
  input  logic             cmd_ilv,
  input  logic             stop_req,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last
);
  localparam int unsigned IDX_W = MAX_LOG;

  logic             cmd_take;
  logic [IDX_W-1:0] cmd_mask;
  logic [IDX_W-1:0] beat_idx;
  logic [COL_W-1:0] start_q;
  logic [IDX_W-1:0] mask_q;
  order_e           order_q;

  assign cmd_mask = len_mask(len_code_e'(cmd_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      mask_q  <= '0;
      order_q <= ORD_SEQ;
    end else if (cmd_take) begin
      start_q <= cmd_col;
      mask_q  <= cmd_mask;
      order_q <= order_e'(cmd_ilv);
    end
  end

  bseq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_take   (cmd_take),
    .end_idx    (cmd_mask),
    .stop_req   (stop_req),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_last  (beat_last),
    .beat_idx   (beat_idx)
  );

  bseq_addr_gen #(.COL_W(COL_W), .IDX_W(IDX_W)) u_addr (
    .start_col (start_q),
    .win_mask  (mask_q),
    .ilv       (order_q == ORD_ILV),
    .idx       (beat_idx),
    .col       (beat_col)
  );

  // R1: first beat repeats the command column
  a_r1_first_col: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (beat_valid && beat_col == $past(cmd_col)));
  // R2/R3: bits above the window never change within a burst
  a_r2_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last) |=>
      (beat_valid && beat_col[COL_W-1:IDX_W] == $past(beat_col[COL_W-1:IDX_W])));
  // R7: a stalled beat keeps its address
  a_r7_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> $stable(beat_col));
  // R9: idle block offers to take a command
  a_r9_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> cmd_ready);
endmodule

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [COL_W-1:0] cmd_col = '0;
  logic [1:0]       cmd_len = '0;
  logic             cmd_ilv = 1'b0;
  logic             stop_req = 1'b0;
  logic             beat_valid;
  logic             beat_ready = 1'b0;
  logic [COL_W-1:0] beat_col;
  logic             beat_last;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench model of the running burst
  bit               m_busy = 1'b0;
  int               m_k = 0;
  logic [COL_W-1:0] m_start = '0;
  logic [1:0]       m_len = '0;
  logic             m_ilv = 1'b0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_col(cmd_col),
    .cmd_len(cmd_len), .cmd_ilv(cmd_ilv), .stop_req(stop_req),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_col(beat_col), .beat_last(beat_last)
  );

  function automatic int beats_of(input logic [1:0] code);
    return (code == 2'd0) ? 2 : (code == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
      input logic [1:0] code, input logic ilv, input int k);
    int bl = beats_of(code);
    int lo = int'(s) % bl;
    int base = int'(s) - lo;
    int off = ilv ? (lo ^ k) : ((lo + k) % bl);
    return COL_W'(base + off);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called just after inputs are set following a falling edge.
  task automatic step();
    bit exp_last;
    bit exp_rdy;
    #1;
    exp_last = m_busy && ((m_k == beats_of(m_len) - 1) || stop_req);
    exp_rdy  = !m_busy || (beat_ready && exp_last);
    check(m_busy ? "R7" : (stop_req ? "R6" : "R10"), "beat_valid", beat_valid, m_busy);
    check("R8", "cmd_ready", cmd_ready, exp_rdy);
    if (m_busy) begin
      check(m_k == 0 ? "R1" : (m_ilv ? "R3" : "R2"), "beat_col",
            beat_col, exp_col(m_start, m_len, m_ilv, m_k));
      check(stop_req ? "R6" : (m_k == beats_of(m_len) - 1 ? "R4" : "R5"),
            "beat_last", beat_last, exp_last);
      if (beat_ready) begin
        if (exp_last) m_busy = 1'b0;
        else m_k++;
      end
    end
    if (cmd_valid && exp_rdy) begin
      m_busy = 1'b1; m_k = 0;
      m_start = cmd_col; m_len = cmd_len; m_ilv = cmd_ilv;
    end
    @(negedge clk);
  endtask

  task automatic offer(input logic [COL_W-1:0] c, input logic [1:0] l, input logic o);
    cmd_valid = 1'b1; cmd_col = c; cmd_len = l; cmd_ilv = o;
    beat_ready = 1'b1; stop_req = 1'b0;
    step();
    cmd_valid = 1'b0;
    while (m_busy) step();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R9", "beat_valid in reset", beat_valid, 0);
    check("R9", "cmd_ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: stop while idle has no effect
    stop_req = 1'b1; step(); step(); stop_req = 1'b0;
    // R2, R3: odd start, length 8, both orders
    offer(10'h005, 2'd2, 1'b0);
    offer(10'h005, 2'd2, 1'b1);
    // R2, R4: top column wraps inside its window; code 3 acts as 8
    offer(10'h3FF, 2'd3, 1'b0);
    offer(10'h3FE, 2'd1, 1'b1);
    offer(10'h201, 2'd0, 1'b0);
    // R8: back-to-back commands held valid
    cmd_valid = 1'b1; cmd_col = 10'h012; cmd_len = 2'd1; cmd_ilv = 1'b0; beat_ready = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      cmd_col = cmd_col + 10'd7;
    end
    cmd_valid = 1'b0;
    while (m_busy) step();

    // random mix
    for (int i = 0; i < 20000; i++) begin
      cmd_valid  = ($urandom % 3) != 0;
      cmd_col    = COL_W'($urandom);
      cmd_len    = 2'($urandom);
      cmd_ilv    = 1'($urandom);
      beat_ready = ($urandom % 4) != 0;
      stop_req   = ($urandom % 12) == 0;
      step();
    end
    cmd_valid = 1'b0; stop_req = 1'b0; beat_ready = 1'b1;
    while (m_busy) step();
    step();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule